// File: doc/BRIEF.md
# Neutral-Point Balance Duration Tracker

This block tracks the neutral-point charge balance of a three-level clamped inverter purely from timing, with no voltage sensing. Each time the modulator commits a vector, it reports the vector index, which of the two DC-link capacitors the chosen switching state draws from, and how long the vector was held, in microseconds. Only the six half-voltage vectors move the balance. Time drawn from the upper capacitor is added to a signed running sum, and time drawn from the lower capacitor is subtracted from it.

When the sum leaves a symmetric window, the capacitor that has supplied more charge is the weaker one. The block then tells the state selector to use only switching states that draw from the other capacitor, which is the one holding the higher voltage. The restriction lifts as soon as the sum is back inside the window. The sum saturates and does not wrap. A synchronous clear restarts the tracking.

Top module: `npb_balance_tracker`

## Requirements
- R1: During and after synchronous reset, `balance_sum` is 0 and `restrict_code` is 0.
- R2: On a clock edge where `log_valid` is 1, `vec_idx` is 1 to 6 and `load_upper` is 1, `balance_sum` rises by `dwell_us` at that edge.
- R3: On a clock edge where `log_valid` is 1, `vec_idx` is 1 to 6 and `load_upper` is 0, `balance_sum` falls by `dwell_us` at that edge.
- R4: A logged vector whose index is 0 or 7 and above leaves `balance_sum` unchanged.
- R5: `balance_sum` saturates at +32767 and at -32767. It never wraps and never takes the value -32768.
- R6: One clock after `balance_sum` exceeds +200, `restrict_code` is 2, meaning only lower-capacitor states may be used.
- R7: One clock after `balance_sum` is below -200, `restrict_code` is 1, meaning only upper-capacitor states may be used.
- R8: One clock after `balance_sum` lies within -200 to +200 inclusive, `restrict_code` is 0, meaning any state may be used. Code 3 never appears.
- R9: `clr` sets `balance_sum` to 0 and `restrict_code` to 0 at the same edge, and takes priority over a simultaneous `log_valid`.
- R10: With `log_valid` and `clr` both low, `balance_sum` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the sum and the restriction |
| log_valid | input | 1 | One dwell is logged at this edge |
| vec_idx | input | 5 | Index of the applied voltage vector |
| load_upper | input | 1 | 1: the state draws from the upper capacitor; 0: from the lower one |
| dwell_us | input | 10 | Dwell time in 1 µs units |
| restrict_code | output | 2 | 0 any state, 1 upper-only, 2 lower-only |
| balance_sum | output | 16 | Signed accumulated balance in µs |

## Verification
`balance_sum` is registered and changes at the edge that samples `log_valid`. `restrict_code` is derived from that registered sum and appears one edge later, except after clear and reset, where both change at the same edge. The bench drives inputs on the falling edge. It reads the sum at the first falling edge after the logging edge and the restriction at the falling edge after that. Clear and reset are checked at the first falling edge after the edge that samples them.

// File: rtl/npb_pkg.sv
package npb_pkg;
  typedef enum logic [1:0] {
    RS_FREE       = 2'd0,
    RS_UPPER_ONLY = 2'd1,
    RS_LOWER_ONLY = 2'd2
  } restrict_e;
endpackage

// File: rtl/npb_classify.sv
// Decides whether a logged vector moves the balance and with which sign.
module npb_classify #(
  parameter int IDX_W      = 5,
  parameter int DWELL_W    = 10,
  parameter int FIRST_HALF = 1,
  parameter int NUM_HALF   = 6,
  localparam int DELTA_W   = DWELL_W + 1
) (
  input  logic                      valid,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      upper,
  input  logic [DWELL_W-1:0]        dwell,
  output logic                      contrib,
  output logic signed [DELTA_W-1:0] delta
);
  logic [NUM_HALF-1:0] hit;

  for (genvar g = 0; g < NUM_HALF; g++) begin : g_hit
    assign hit[g] = (idx == IDX_W'(FIRST_HALF + g));
  end

  logic signed [DELTA_W-1:0] mag;

  always_comb begin
    mag     = $signed({1'b0, dwell});
    contrib = valid && (|hit);
    delta   = upper ? mag : -mag;
  end
endmodule

// File: rtl/npb_accum.sv
// Saturating signed accumulator of the balance.
module npb_accum #(
  parameter int SUM_W   = 16,
  parameter int DELTA_W = 11,
  localparam int EXT_W  = SUM_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      add_en,
  input  logic signed [DELTA_W-1:0] delta,
  output logic signed [SUM_W-1:0]   sum_q
);
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'((2 ** (SUM_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [EXT_W-1:0] wide;
  logic signed [SUM_W-1:0] sum_d;

  always_comb begin
    wide = $signed({{(EXT_W - SUM_W){sum_q[SUM_W-1]}}, sum_q})
         + $signed({{(EXT_W - DELTA_W){delta[DELTA_W-1]}}, delta});
    if (wide > POS_LIM)      sum_d = POS_LIM[SUM_W-1:0];
    else if (wide < NEG_LIM) sum_d = NEG_LIM[SUM_W-1:0];
    else                     sum_d = wide[SUM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  sum_q <= '0;
    else if (add_en) sum_q <= sum_d;
  end
endmodule

// File: rtl/npb_window.sv
// Registered window test producing the restriction code.
module npb_window
  import npb_pkg::*;
#(
  parameter int SUM_W = 16,
  parameter int LIMIT = 200
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic signed [SUM_W-1:0] sum,
  output restrict_e               code_q
);
  localparam logic signed [SUM_W-1:0] HI = SUM_W'(LIMIT);
  localparam logic signed [SUM_W-1:0] LO = -HI;

  restrict_e code_d;

  always_comb begin
    if (sum > HI)      code_d = RS_LOWER_ONLY;
    else if (sum < LO) code_d = RS_UPPER_ONLY;
    else               code_d = RS_FREE;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) code_q <= RS_FREE;
    else            code_q <= code_d;
  end
endmodule

// File: rtl/npb_balance_tracker.sv
module npb_balance_tracker
  import npb_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int DWELL_W    = 10,
  parameter int SUM_W      = 16,
  parameter int LIMIT      = 200,
  parameter int FIRST_HALF = 1,
  parameter int NUM_HALF   = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    log_valid,
  input  logic [IDX_W-1:0]        vec_idx,
  input  logic                    load_upper,
  input  logic [DWELL_W-1:0]      dwell_us,
  output logic [1:0]              restrict_code,
  output logic signed [SUM_W-1:0] balance_sum
);
  localparam int DELTA_W = DWELL_W + 1;

  logic                      contrib;
  logic signed [DELTA_W-1:0] delta;
  restrict_e                 code;

  npb_classify #(
    .IDX_W(IDX_W), .DWELL_W(DWELL_W),
    .FIRST_HALF(FIRST_HALF), .NUM_HALF(NUM_HALF)
  ) u_cls (
    .valid(log_valid), .idx(vec_idx), .upper(load_upper), .dwell(dwell_us),
    .contrib(contrib), .delta(delta)
  );

  npb_accum #(.SUM_W(SUM_W), .DELTA_W(DELTA_W)) u_acc (
    .clk(clk), .rst(rst), .clr(clr), .add_en(contrib), .delta(delta),
    .sum_q(balance_sum)
  );

  npb_window #(.SUM_W(SUM_W), .LIMIT(LIMIT)) u_win (
    .clk(clk), .rst(rst), .clr(clr), .sum(balance_sum), .code_q(code)
  );

  assign restrict_code = code;
endmodule

// File: rtl/npb_balance_checker.sv
module npb_balance_checker #(
  parameter int IDX_W      = 5,
  parameter int DWELL_W    = 10,
  parameter int SUM_W      = 16,
  parameter int LIMIT      = 200,
  parameter int FIRST_HALF = 1,
  parameter int NUM_HALF   = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    clr,
  input logic                    log_valid,
  input logic [IDX_W-1:0]        vec_idx,
  input logic [1:0]              restrict_code,
  input logic signed [SUM_W-1:0] balance_sum
);
  localparam logic signed [SUM_W-1:0] HI  = SUM_W'(LIMIT);
  localparam logic signed [SUM_W-1:0] LO  = -HI;
  localparam logic signed [SUM_W-1:0] MIN = {1'b1, {(SUM_W - 1){1'b0}}};

  logic idx_out;
  assign idx_out = (vec_idx < IDX_W'(FIRST_HALF)) ||
                   (vec_idx >= IDX_W'(FIRST_HALF + NUM_HALF));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (balance_sum == '0 && restrict_code == 2'd0));

  assert_ignored_index_R4: assert property (@(posedge clk) disable iff (rst)
    (log_valid && !clr && idx_out) |=> $stable(balance_sum));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    balance_sum != MIN);

  assert_lower_only_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && balance_sum > HI) |=> restrict_code == 2'd2);

  assert_upper_only_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && balance_sum < LO) |=> restrict_code == 2'd1);

  assert_free_inside_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && balance_sum <= HI && balance_sum >= LO) |=> restrict_code == 2'd0);

  assert_no_code3_R8: assert property (@(posedge clk) disable iff (rst)
    restrict_code != 2'd3);

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (balance_sum == '0 && restrict_code == 2'd0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!log_valid && !clr) |=> $stable(balance_sum));
endmodule

bind npb_balance_tracker npb_balance_checker #(
  .IDX_W(IDX_W), .DWELL_W(DWELL_W), .SUM_W(SUM_W), .LIMIT(LIMIT),
  .FIRST_HALF(FIRST_HALF), .NUM_HALF(NUM_HALF)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .log_valid(log_valid), .vec_idx(vec_idx),
  .restrict_code(restrict_code), .balance_sum(balance_sum)
);

// File: tb/tb_npb_balance_tracker.sv
module tb_npb_balance_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 10;

  // per row: index, upper flag, dwell, expected sum, expected code
  localparam int T_IDX [NT]  = '{1, 2, 3, 4, 0, 7, 6, 5, 11, 1};
  localparam int T_UP  [NT]  = '{1, 1, 1, 0, 1, 1, 0, 0, 0, 1};
  localparam int T_DW  [NT]  = '{150, 50, 1, 1, 300, 300, 400, 1, 500, 201};
  localparam int T_SUM [NT]  = '{150, 200, 201, 200, 200, 200, -200, -201, -201, 0};
  localparam int T_CODE[NT]  = '{0, 0, 2, 0, 0, 0, 0, 1, 1, 0};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clr = 1'b0;
  logic              log_valid = 1'b0;
  logic [4:0]        vec_idx = '0;
  logic              load_upper = 1'b0;
  logic [9:0]        dwell_us = '0;
  logic [1:0]        restrict_code;
  logic signed [15:0] balance_sum;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  npb_balance_tracker dut (
    .clk(clk), .rst(rst), .clr(clr), .log_valid(log_valid), .vec_idx(vec_idx),
    .load_upper(load_upper), .dwell_us(dwell_us),
    .restrict_code(restrict_code), .balance_sum(balance_sum)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic log_step(input int idx, input int up, input int dw,
                          input int exp_sum, input int exp_code, input string req);
    @(negedge clk);
    vec_idx = 5'(idx); load_upper = up[0]; dwell_us = 10'(dw); log_valid = 1'b1;
    @(negedge clk);
    log_valid = 1'b0;
    check({req, " sum"}, int'(balance_sum), exp_sum);
    @(negedge clk);
    check({req, " code"}, int'(restrict_code), exp_code);
  endtask

  task automatic burst(input int up, input int count);
    @(negedge clk);
    vec_idx = 5'd3; load_upper = up[0]; dwell_us = 10'd1023; log_valid = 1'b1;
    for (int i = 0; i < count; i++) @(negedge clk);
    log_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset sum", int'(balance_sum), 0);
    check("R1 reset code", int'(restrict_code), 0);
    rst = 1'b0;

    // R2 R3 R4 R6 R7 R8 walked from the table
    for (int i = 0; i < NT; i++)
      log_step(T_IDX[i], T_UP[i], T_DW[i], T_SUM[i], T_CODE[i], $sformatf("R2/R3/R4/R6/R7/R8 row%0d", i));

    // R10: idle cycles hold the sum
    log_step(2, 1, 77, 77, 0, "R2 idle setup");
    repeat (5) @(negedge clk);
    check("R10 hold", int'(balance_sum), 77);

    // R5 positive saturation: 33 * 1023 exceeds 32767
    burst(1, 33);
    check("R5 pos sat", int'(balance_sum), 32767);
    @(negedge clk);
    check("R6 sat code", int'(restrict_code), 2);
    log_step(3, 1, 1023, 32767, 2, "R5 pos stay");
    log_step(3, 0, 1023, 31744, 2, "R5 leave sat");

    // R9: clear beats a simultaneous log
    @(negedge clk);
    clr = 1'b1; log_valid = 1'b1; vec_idx = 5'd1; load_upper = 1'b1; dwell_us = 10'd500;
    @(negedge clk);
    clr = 1'b0; log_valid = 1'b0;
    check("R9 clear sum", int'(balance_sum), 0);
    check("R9 clear code", int'(restrict_code), 0);

    // R5 negative saturation
    burst(0, 33);
    check("R5 neg sat", int'(balance_sum), -32767);
    @(negedge clk);
    check("R7 neg sat code", int'(restrict_code), 1);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 rerun sum", int'(balance_sum), 0);
    check("R1 rerun code", int'(restrict_code), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule